// File: doc/BRIEF.md
# Staged Coefficient Commit Buffer

This block sits between a host-side register-write port and a 1024-word by 28-bit coefficient memory. A DSP core reads that memory every sample. The host fills up to five staging slots. Each slot holds a target address and a 28-bit data word. The host then writes a control word that arms a commit for the first N slots.

The block waits for the next audio-frame start strobe. It then copies the armed slots into the coefficient memory in slot order, one write per cycle in which the core is not using the memory. All the coefficients of one filter section therefore change together within one frame. The core never competes with the block for the memory.

While a commit is armed or running, every host write is refused and flagged, so the staged values cannot change part-way through a transfer. The staging path reaches only the coefficient memory. A target address that falls outside it is refused.

Top module: `coef_stage_commit`

## Requirements
- R1: There are five slots. A host write with `host_sel` 0..4 sets the data word of that slot from `host_wdata[27:0]`. A write with `host_sel` 8..12 sets the target address of slot `host_sel-8` from `host_wdata[11:0]`.
- R2: An address write whose 12-bit value is 1024 or more is refused. The slot keeps its old address, and `host_reject` is high for the one cycle after the write.
- R3: A control write (`host_sel` 15) with bit 3 set and a count of 1..5 in bits 2:0 arms a commit. `xfer_busy` is high from the cycle after that write. No memory write happens before a `frame_start` that is sampled while the commit is armed.
- R4: After that `frame_start`, slots 0 to count-1 are written in ascending order, one per cycle. `ram_we` is never high in a cycle in which `core_busy` is high.
- R5: Slots at or above the armed count are not written.
- R6: Exactly count writes are made. `xfer_busy` falls right after the clock edge of the last write.
- R7: Any host write while `xfer_busy` is high is refused, with a `host_reject` pulse. The slot contents stay as they were, which a later commit shows.
- R8: A control write with the trigger bit set and a count of 0, 6 or 7 is refused with a reject pulse. Writes to `host_sel` 5..7, 13 or 14 are also refused with a reject pulse. A control write with bit 3 clear does nothing and raises no reject.
- R9: After reset every slot holds address 0 and data 0, the block is idle, and `ram_we` and `host_reject` are low.
- R10: A `frame_start` while the block is idle, or while a copy is running, has no effect.
- R11: A commit leaves the slots unchanged, so arming again writes the same values again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 4 | Host register select |
| host_wdata | input | 28 | Host write data |
| frame_start | input | 1 | Audio-frame start strobe |
| core_busy | input | 1 | Core is accessing the coefficient memory this cycle |
| ram_we | output | 1 | Coefficient memory write enable |
| ram_addr | output | 10 | Coefficient memory write address |
| ram_wdata | output | 28 | Coefficient memory write data |
| xfer_busy | output | 1 | A commit is armed or in progress |
| host_reject | output | 1 | One-cycle pulse: the previous host write was refused |

## Verification
The bench stalls the copy with a randomly busy core and sends extra frame strobes while a copy runs. A design that ignored `core_busy` would write into the core's access cycles. A design that restarted on the second strobe would write some slots twice.

The bench pokes slot registers both while a commit is armed and during the copy. Any leak shows up as changed values in that commit or the next one. The bench also arms counts below five, where a design with an off-by-one stop would write one slot too many or too few.

Out-of-range addresses, illegal counts and unused selects are each followed by a commit. A design that accepted any of them would write a wrong address into the memory.

// File: rtl/csc_pkg.sv
package csc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COPY  = 2'd2
    } csc_state_e;

    localparam logic [3:0] SEL_CTRL      = 4'd15;
    localparam int         SEL_ADDR_BASE = 8;
endpackage

// File: rtl/csc_slot_bank.sv
module csc_slot_bank
    import csc_pkg::*;
#(
    parameter int NSLOT = 5,
    parameter int DW    = 28,
    parameter int AW    = 10,
    parameter int TAW   = 12,
    parameter int SELW  = 4,
    parameter int CNTW  = 3,
    parameter int IDXW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic [SELW-1:0] host_sel,
    input  logic [DW-1:0]   host_wdata,
    input  logic            lock,
    input  logic [IDXW-1:0] rd_idx,
    output logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            go,
    output logic [CNTW-1:0] go_cnt,
    output logic            reject
);
    typedef struct packed {
        logic [NSLOT-1:0][AW-1:0] addr;
        logic [NSLOT-1:0][DW-1:0] data;
        logic                     rej;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  hit;

    always_comb begin
        bank_d     = bank_q;
        bank_d.rej = 1'b0;
        go         = 1'b0;
        go_cnt     = host_wdata[CNTW-1:0];
        hit        = 1'b0;
        if (host_we) begin
            if (lock) begin
                bank_d.rej = 1'b1;
            end else if (host_sel == SEL_CTRL) begin
                hit = 1'b1;
                if (host_wdata[CNTW]) begin
                    if (go_cnt != '0 && go_cnt <= CNTW'(NSLOT)) go = 1'b1;
                    else bank_d.rej = 1'b1;
                end
            end else begin
                for (int i = 0; i < NSLOT; i++) begin
                    if (host_sel == SELW'(i)) begin
                        hit              = 1'b1;
                        bank_d.data[i]   = host_wdata;
                    end
                    if (host_sel == SELW'(SEL_ADDR_BASE + i)) begin
                        hit = 1'b1;
                        if (host_wdata[TAW-1:AW] == '0) bank_d.addr[i] = host_wdata[AW-1:0];
                        else bank_d.rej = 1'b1;
                    end
                end
                if (!hit) bank_d.rej = 1'b1;
            end
        end
    end

    always_comb begin
        rd_addr = '0;
        rd_data = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (rd_idx == IDXW'(i)) begin
                rd_addr = bank_q.addr[i];
                rd_data = bank_q.data[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign reject = bank_q.rej;
endmodule

// File: rtl/csc_sequencer.sv
module csc_sequencer
    import csc_pkg::*;
#(
    parameter int NSLOT = 5,
    parameter int CNTW  = 3,
    parameter int IDXW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [CNTW-1:0] go_cnt,
    input  logic            frame_start,
    input  logic            core_busy,
    output logic            busy,
    output logic            we,
    output logic [IDXW-1:0] idx
);
    typedef struct packed {
        csc_state_e      st;
        logic [IDXW-1:0] idx;
        logic [IDXW-1:0] last;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (go) begin
                    seq_d.st   = ST_ARMED;
                    seq_d.last = IDXW'(go_cnt - CNTW'(1));
                end
            end
            ST_ARMED: begin
                if (frame_start) begin
                    seq_d.st  = ST_COPY;
                    seq_d.idx = '0;
                end
            end
            ST_COPY: begin
                if (!core_busy) begin
                    if (seq_q.idx == seq_q.last) seq_d.st = ST_IDLE;
                    else seq_d.idx = seq_q.idx + IDXW'(1);
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, idx: '0, last: '0};
        else        seq_q <= seq_d;
    end

    assign busy = (seq_q.st != ST_IDLE);
    assign we   = (seq_q.st == ST_COPY) && !core_busy;
    assign idx  = seq_q.idx;
endmodule

// File: rtl/coef_stage_commit.sv
module coef_stage_commit #(
    parameter int NSLOT = 5,
    parameter int DW    = 28,
    parameter int AW    = 10,
    parameter int TAW   = 12,
    parameter int SELW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic [SELW-1:0] host_sel,
    input  logic [DW-1:0]   host_wdata,
    input  logic            frame_start,
    input  logic            core_busy,
    output logic            ram_we,
    output logic [AW-1:0]   ram_addr,
    output logic [DW-1:0]   ram_wdata,
    output logic            xfer_busy,
    output logic            host_reject
);
    localparam int CNTW = $clog2(NSLOT + 1);
    localparam int IDXW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic            go;
    logic [CNTW-1:0] go_cnt;
    logic [IDXW-1:0] idx;

    csc_slot_bank #(
        .NSLOT(NSLOT), .DW(DW), .AW(AW), .TAW(TAW),
        .SELW(SELW), .CNTW(CNTW), .IDXW(IDXW)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .lock       (xfer_busy),
        .rd_idx     (idx),
        .rd_addr    (ram_addr),
        .rd_data    (ram_wdata),
        .go         (go),
        .go_cnt     (go_cnt),
        .reject     (host_reject)
    );

    csc_sequencer #(
        .NSLOT(NSLOT), .CNTW(CNTW), .IDXW(IDXW)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .go_cnt      (go_cnt),
        .frame_start (frame_start),
        .core_busy   (core_busy),
        .busy        (xfer_busy),
        .we          (ram_we),
        .idx         (idx)
    );
endmodule

// File: rtl/csc_checker.sv
module csc_checker (
    input logic clk,
    input logic rst_n,
    input logic host_we,
    input logic core_busy,
    input logic ram_we,
    input logic xfer_busy,
    input logic host_reject
);
    a_r4_no_write_while_core_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !core_busy);

    a_r7_reject_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && xfer_busy) |=> host_reject);

    a_r3_arm_needs_host_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> $past(host_we));

    a_r3_no_write_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy |=> !ram_we);

    a_r6_writes_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> xfer_busy);
endmodule

bind coef_stage_commit csc_checker u_csc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_we     (host_we),
    .core_busy   (core_busy),
    .ram_we      (ram_we),
    .xfer_busy   (xfer_busy),
    .host_reject (host_reject)
);

// File: tb/coef_stage_commit_bench.sv
module coef_stage_commit_bench;
    localparam int NSLOT = 5;
    localparam int DW    = 28;
    localparam int AW    = 10;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          host_we;
    logic [3:0]    host_sel;
    logic [DW-1:0] host_wdata;
    logic          frame_start;
    logic          core_busy;
    logic          ram_we;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          xfer_busy;
    logic          host_reject;

    always #5 clk = ~clk;

    coef_stage_commit u_coef_stage_commit (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .frame_start(frame_start), .core_busy(core_busy),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .xfer_busy(xfer_busy), .host_reject(host_reject)
    );

    int            nvec = 0;
    int            nerr = 0;
    logic [AW-1:0] m_addr [NSLOT];
    logic [DW-1:0] m_data [NSLOT];
    logic [AW-1:0] lg_addr [64];
    logic [DW-1:0] lg_data [64];
    int            lg_n;
    bit            bad_busy;
    bit            last_rej;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        #1;
        if (ram_we) begin
            if (lg_n < 64) begin
                lg_addr[lg_n] = ram_addr;
                lg_data[lg_n] = ram_wdata;
            end
            lg_n++;
            if (core_busy) bad_busy = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic hwr(input logic [3:0] sel, input logic [DW-1:0] d);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        cyc();
        host_we = 1'b0; host_sel = '0; host_wdata = '0;
        #1 last_rej = host_reject;
    endtask

    task automatic wr_data(input int i, input logic [DW-1:0] d, input bit locked);
        hwr(4'(i), d);
        chk(last_rej == locked, locked ? "R7 data write locked" : "R1 data write", 64'(last_rej), 64'(locked));
        if (!locked) m_data[i] = d;
    endtask

    task automatic wr_addr(input int i, input logic [11:0] a, input bit locked);
        bit exp_rej;
        exp_rej = locked || (a >= 12'd1024);
        hwr(4'(8 + i), {16'b0, a});
        chk(last_rej == exp_rej, locked ? "R7 addr write locked" : "R2 addr range", 64'(last_rej), 64'(exp_rej));
        if (!exp_rej) m_addr[i] = a[AW-1:0];
    endtask

    task automatic commit(input int cnt, input int busy_pct, input bit poke);
        int guard;
        hwr(4'd15, {24'b0, 1'b1, 3'(cnt)});
        chk(last_rej == 1'b0, "R3 arm accepted", 64'(last_rej), 64'd0);
        chk(xfer_busy == 1'b1, "R3 busy after arm", 64'(xfer_busy), 64'd1);
        lg_n = 0; bad_busy = 1'b0;
        cyc(); cyc();
        if (poke) begin
            wr_data(0, 28'(~m_data[0]), 1'b1);
            wr_addr(1, 12'(m_addr[1] + 1), 1'b1);
        end
        chk(lg_n == 0, "R3 no write before frame", 64'(lg_n), 64'd0);
        frame_start = 1'b1;
        cyc();
        frame_start = 1'b0;
        guard = 0;
        while (xfer_busy && guard < 400) begin
            core_busy   = (($urandom % 100) < busy_pct);
            frame_start = (($urandom % 8) == 0); // R10 strobe during copy
            if (poke && guard == 1) wr_data(2, 28'h5A5A5A5, 1'b1);
            else cyc();
            guard++;
        end
        core_busy = 1'b0; frame_start = 1'b0;
        chk(xfer_busy == 1'b0, "R6 busy falls", 64'(xfer_busy), 64'd0);
        chk(lg_n == cnt, "R5 R6 write count", 64'(lg_n), 64'(cnt));
        chk(!bad_busy, "R4 write with core busy", 64'(bad_busy), 64'd0);
        for (int i = 0; i < cnt && i < lg_n; i++) begin
            chk(lg_addr[i] == m_addr[i], $sformatf("R4 order addr slot %0d", i), 64'(lg_addr[i]), 64'(m_addr[i]));
            chk(lg_data[i] == m_data[i], $sformatf("R4 order data slot %0d", i), 64'(lg_data[i]), 64'(m_data[i]));
        end
    endtask

    task automatic expect_drop(input logic [3:0] sel, input logic [DW-1:0] d, input string tag);
        hwr(sel, d);
        chk(last_rej == 1'b1, tag, 64'(last_rej), 64'd1);
        chk(xfer_busy == 1'b0, {tag, " stays idle"}, 64'(xfer_busy), 64'd0);
    endtask

    bit finished = 1'b0;

    initial begin
        #2_000_000;
        if (!finished) begin
            nvec++; nerr++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        rst_n = 1'b0; host_we = 1'b0; host_sel = '0; host_wdata = '0;
        frame_start = 1'b0; core_busy = 1'b0; lg_n = 0; bad_busy = 1'b0; last_rej = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin m_addr[i] = '0; m_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(xfer_busy == 1'b0, "R9 idle after reset", 64'(xfer_busy), 64'd0);
        chk(ram_we == 1'b0, "R9 no write after reset", 64'(ram_we), 64'd0);
        chk(host_reject == 1'b0, "R9 no reject after reset", 64'(host_reject), 64'd0);
        @(negedge clk);
        commit(5, 0, 1'b0); // R9 slots zero

        // R10 frame while idle
        lg_n = 0;
        frame_start = 1'b1; cyc(); frame_start = 1'b0;
        cyc(); cyc();
        chk(lg_n == 0 && xfer_busy == 1'b0, "R10 idle frame ignored", 64'(lg_n), 64'd0);

        for (int i = 0; i < NSLOT; i++) begin
            wr_addr(i, 12'(100 * i + 7), 1'b0);
            wr_data(i, 28'(32'h0800000 + i * 32'h1111), 1'b0);
        end
        commit(5, 0, 1'b0);

        wr_addr(0, 12'd1023, 1'b0);
        wr_addr(1, 12'd1024, 1'b0);
        wr_addr(2, 12'hFFF, 1'b0);
        commit(3, 30, 1'b0);

        expect_drop(4'd15, {24'b0, 4'b1000}, "R8 count zero");
        expect_drop(4'd15, {24'b0, 4'b1110}, "R8 count six");
        expect_drop(4'd15, {24'b0, 4'b1111}, "R8 count seven");
        expect_drop(4'd5,  28'h1234, "R8 sel 5");
        expect_drop(4'd7,  28'h1234, "R8 sel 7");
        expect_drop(4'd13, 28'h0010, "R8 sel 13");
        expect_drop(4'd14, 28'h0010, "R8 sel 14");
        hwr(4'd15, {24'b0, 4'b0011});
        chk(last_rej == 1'b0 && xfer_busy == 1'b0, "R8 trigger clear no-op", 64'({last_rej, xfer_busy}), 64'd0);

        commit(3, 60, 1'b1);  // R7
        commit(2, 40, 1'b0);  // R11 same values again
        commit(1, 80, 1'b0);

        for (int it = 0; it < 25; it++) begin
            for (int k = 0; k < 3; k++) begin
                int s;
                s = $urandom % NSLOT;
                if ($urandom % 2) wr_addr(s, 12'($urandom % 1200), 1'b0);
                else wr_data(s, 28'($urandom), 1'b0);
            end
            commit(1 + ($urandom % NSLOT), $urandom % 90, ($urandom % 4) == 0);
            repeat ($urandom % 3) cyc();
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule